// File: doc/BRIEF.md
# Speculative Load Order Guard

This block watches loads that have already read their data from the cache but have not yet retired. If another agent invalidates the cache line behind one of those loads before the load is safe, the value the load obtained may be one that an observer could see out of order with respect to an older load. The block makes that reordering impossible to observe. It asks the pipeline to flush and to restart at the oldest load that was hit, and it drops that load and everything younger from its own tracking in the same step.

The pipeline reports a load to the block when its value is bound. The report carries the load's age tag, its address and a flag that marks a non-coherent region. Each age tag is one bit wider than the slot index, so that ages compare correctly across wraparound. The pipeline also reports retirement, and it reports the age of the oldest load that is still waiting for its value. A tracked load whose older loads all have their values can no longer cause an observable violation, so the block stops tracking it at that point. Each invalidation snoop carries a byte address and is compared at cache-line granularity.

Top module: `load_order_guard`

## Requirements
- R1: While reset is asserted and on the first edge after it, `flush_valid` is 0. Reset forgets every tracked load, so a snoop after reset to a line that was tracked before reset gives no flush.
- R2: A coherent load bound with age tag T stays tracked. A snoop to its line raises `flush_valid` with `flush_tag` = T on the clock edge that ends the snoop cycle.
- R3: Addresses are compared by cache line, which is every bit above the low OFF_W bits (4 by default). Addresses that differ only in those bits match. Addresses that differ above them do not match.
- R4: When several tracked loads match one snoop, `flush_tag` is the oldest of them. Ages are compared as wrap-aware tags of IDX_W+1 bits. For tags with equal top bits, the smaller low part is older. For tags with different top bits, the larger low part is older.
- R5: On the edge that raises a flush, every tracked load at or younger than `flush_tag` is dropped. Older tracked loads stay tracked and can still cause a later flush.
- R6: A load bound with `bind_noncoh` = 1 is never tracked. It gives no flush, including when the snoop arrives in the same cycle as the bind.
- R7: A retired load stops being tracked. A later snoop to its line gives no flush.
- R8: Once `unbound_valid` is 1 and a tracked load is strictly older than `unbound_tag`, or once `unbound_valid` is 0, that load stops being tracked on the next edge.
- R9: A coherent load that binds in the same cycle as a snoop to its line counts as hit. If it is the oldest hit, it is the restart age. It is not kept in tracking when it is at or younger than the restart age.
- R10: A load that retires in the same cycle as a snoop to its line does not cause a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bind_valid | input | 1 | A load bound its value this cycle |
| bind_tag | input | IDX_W+1 | Age tag of the binding load |
| bind_addr | input | ADDR_W | Byte address of the binding load |
| bind_noncoh | input | 1 | Binding load targets a non-coherent region |
| retire_valid | input | 1 | A load retires this cycle |
| retire_tag | input | IDX_W+1 | Age tag of the retiring load |
| snoop_valid | input | 1 | An invalidation snoop arrives this cycle |
| snoop_addr | input | ADDR_W | Byte address of the invalidated line |
| unbound_valid | input | 1 | At least one load is still waiting for its value |
| unbound_tag | input | IDX_W+1 | Age tag of the oldest load still waiting |
| flush_valid | output | 1 | Flush request, one cycle per hit snoop |
| flush_tag | output | IDX_W+1 | Age tag at which execution restarts |

## Verification
A snoop is seen in the cycle it is presented. Its flush appears on `flush_valid` and `flush_tag` after exactly one clock edge. Bind, retire and release take effect on that same edge, so a change in tracking shows up as the flush result of the next snoop, one cycle later. The bench drives each cycle's inputs after the falling edge. It compares the flush outputs shortly after the following rising edge, which is the only edge between stimulus and result. Tracking state is therefore always judged through the flush a later snoop does or does not cause.

// File: rtl/load_order_guard.sv
module load_order_guard #(
  parameter int IDX_W = 3,
  parameter int ADDR_W = 16,
  parameter int OFF_W = 4,
  parameter bit EARLY_RELEASE = 1'b1,
  localparam int AGE_W = IDX_W + 1,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bind_valid,
  input  logic [AGE_W-1:0]  bind_tag,
  input  logic [ADDR_W-1:0] bind_addr,
  input  logic              bind_noncoh,
  input  logic              retire_valid,
  input  logic [AGE_W-1:0]  retire_tag,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              unbound_valid,
  input  logic [AGE_W-1:0]  unbound_tag,
  output logic              flush_valid,
  output logic [AGE_W-1:0]  flush_tag
);
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    if (a[IDX_W] == b[IDX_W]) return a[IDX_W-1:0] < b[IDX_W-1:0];
    return a[IDX_W-1:0] > b[IDX_W-1:0];
  endfunction

  logic [DEPTH-1:0]  vld;
  logic [AGE_W-1:0]  tag_q  [DEPTH];
  logic [LINE_W-1:0] line_q [DEPTH];

  wire [LINE_W-1:0] snoop_line = snoop_addr[ADDR_W-1:OFF_W];
  wire [LINE_W-1:0] bind_line  = bind_addr[ADDR_W-1:OFF_W];
  wire [IDX_W-1:0]  bind_idx   = bind_tag[IDX_W-1:0];
  wire [IDX_W-1:0]  ret_idx    = retire_tag[IDX_W-1:0];
  wire              bind_coh   = bind_valid & ~bind_noncoh;
  wire              bind_hit   = snoop_valid & bind_coh & (bind_line == snoop_line);

  logic [DEPTH-1:0] hit_vec, ret_vec, rel_vec;
  logic             any_hit;
  logic [AGE_W-1:0] oldest;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign ret_vec[i] = retire_valid & vld[i] & (tag_q[i] == retire_tag);
    assign hit_vec[i] = snoop_valid & vld[i] & ~ret_vec[i] & (line_q[i] == snoop_line);
    if (EARLY_RELEASE) begin : g_rel
      assign rel_vec[i] = ~unbound_valid | older(tag_q[i], unbound_tag);
    end else begin : g_norel
      assign rel_vec[i] = 1'b0;
    end
  end

  always_comb begin
    any_hit = bind_hit;
    oldest  = bind_tag;
    for (int i = 0; i < DEPTH; i++)
      if (hit_vec[i] && (!any_hit || older(tag_q[i], oldest))) begin
        any_hit = 1'b1;
        oldest  = tag_q[i];
      end
  end

  wire bind_keep = bind_coh & ~(any_hit & ~older(bind_tag, oldest));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if ((any_hit && !older(tag_q[i], oldest)) || ret_vec[i] || rel_vec[i])
          vld[i] <= 1'b0;
        if (bind_keep && bind_idx == IDX_W'(i)) begin
          vld[i]    <= 1'b1;
          tag_q[i]  <= bind_tag;
          line_q[i] <= bind_line;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush_valid <= 1'b0;
      flush_tag   <= '0;
    end else begin
      flush_valid <= any_hit;
      if (any_hit) flush_tag <= oldest;
    end
  end

  logic young_live;
  always_comb begin
    young_live = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld[i] && !older(tag_q[i], flush_tag)) young_live = 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk) $past(!rst_n) |-> !flush_valid);
  a_r2_flush_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(snoop_valid));
  a_r5_flush_clears_younger: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !young_live);
  a_r6_noncoh_untracked: assert property (@(posedge clk) disable iff (!rst_n)
    bind_valid && bind_noncoh && !vld[bind_idx] |=> !vld[$past(bind_idx)]);
  a_r7_retire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid && vld[ret_idx] && tag_q[ret_idx] == retire_tag
      && !(bind_valid && bind_idx == ret_idx) |=> !vld[$past(ret_idx)]);

  if (EARLY_RELEASE) begin : g_rel_chk
    for (genvar i = 0; i < DEPTH; i++) begin : g_r8
      a_r8_release_older: assert property (@(posedge clk) disable iff (!rst_n)
        unbound_valid && vld[i] && older(tag_q[i], unbound_tag)
          && !(bind_valid && bind_idx == IDX_W'(i)) |=> !vld[i]);
    end
  end
endmodule

// File: tb/sim_load_order_guard.sv
module sim_load_order_guard;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        bv; logic [3:0] bt; logic [15:0] ba; logic nc;
    logic        rv; logic [3:0] rt;
    logic        sv; logic [15:0] sa;
    logic        uv; logic [3:0] ut;
    logic        ef; logic [3:0] et;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [NV] = '{
    // R2 R3 R5 R6: two coherent loads, one non-coherent
    '{1,4'd0,16'h1000,0, 0,4'd0, 0,16'h0000, 1,4'd0, 0,4'd0},
    '{1,4'd1,16'h2000,0, 0,4'd0, 0,16'h0000, 1,4'd0, 0,4'd0},
    '{1,4'd2,16'h3000,1, 0,4'd0, 0,16'h0000, 1,4'd0, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h3008, 1,4'd0, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h200F, 1,4'd0, 1,4'd1},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h2000, 1,4'd0, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h1004, 1,4'd0, 1,4'd0},
    // R4 oldest of several, R3 different line, R5 younger dropped
    '{1,4'd3,16'h4000,0, 0,4'd0, 0,16'h0000, 1,4'd3, 0,4'd0},
    '{1,4'd4,16'h4010,0, 0,4'd0, 0,16'h0000, 1,4'd3, 0,4'd0},
    '{1,4'd5,16'h4000,0, 0,4'd0, 0,16'h0000, 1,4'd3, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h4000, 1,4'd3, 1,4'd3},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h4010, 1,4'd3, 0,4'd0},
    // R4 across the wrap bit: 6 older than 8
    '{1,4'd6,16'h5000,0, 0,4'd0, 0,16'h0000, 1,4'd6, 0,4'd0},
    '{1,4'd7,16'h6000,0, 0,4'd0, 0,16'h0000, 1,4'd6, 0,4'd0},
    '{1,4'd8,16'h5000,0, 0,4'd0, 0,16'h0000, 1,4'd6, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h5000, 1,4'd6, 1,4'd6},
    // R4 wrap: 14 older than 1
    '{1,4'd14,16'h8000,0, 0,4'd0, 0,16'h0000, 1,4'd14, 0,4'd0},
    '{1,4'd1,16'h8000,0, 0,4'd0, 0,16'h0000, 1,4'd14, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h8000, 1,4'd14, 1,4'd14},
    // R7 retired load untracked
    '{1,4'd2,16'h9000,0, 0,4'd0, 0,16'h0000, 1,4'd2, 0,4'd0},
    '{0,4'd0,16'h0000,0, 1,4'd2, 0,16'h0000, 1,4'd2, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h9000, 1,4'd2, 0,4'd0},
    // R10 retire and snoop together
    '{1,4'd3,16'hA000,0, 0,4'd0, 0,16'h0000, 1,4'd3, 0,4'd0},
    '{0,4'd0,16'h0000,0, 1,4'd3, 1,16'hA000, 1,4'd3, 0,4'd0},
    // R9 bind and snoop together
    '{1,4'd4,16'hB000,0, 0,4'd0, 1,16'hB000, 1,4'd4, 1,4'd4},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'hB000, 1,4'd4, 0,4'd0},
    '{1,4'd5,16'hC000,0, 0,4'd0, 0,16'h0000, 1,4'd5, 0,4'd0},
    '{1,4'd6,16'hC000,0, 0,4'd0, 1,16'hC000, 1,4'd5, 1,4'd5},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'hC000, 1,4'd5, 0,4'd0},
    // R8 early release
    '{1,4'd7,16'hD000,0, 0,4'd0, 0,16'h0000, 1,4'd7, 0,4'd0},
    '{1,4'd8,16'hE000,0, 0,4'd0, 0,16'h0000, 1,4'd7, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 0,16'h0000, 1,4'd8, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'hD000, 1,4'd8, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'hE000, 1,4'd8, 1,4'd8},
    '{1,4'd9,16'hF000,0, 0,4'd0, 0,16'h0000, 1,4'd9, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 0,16'h0000, 0,4'd0, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'hF000, 0,4'd0, 0,4'd0},
    // R6 non-coherent bind with same-cycle snoop
    '{1,4'd10,16'h1230,1, 0,4'd0, 1,16'h1230, 1,4'd10, 0,4'd0},
    // R3 offset bits ignored
    '{1,4'd12,16'h2220,0, 0,4'd0, 0,16'h0000, 1,4'd12, 0,4'd0},
    '{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h222F, 1,4'd12, 1,4'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bind_valid = 0, bind_noncoh = 0, retire_valid = 0, snoop_valid = 0, unbound_valid = 0;
  logic [3:0] bind_tag = '0, retire_tag = '0, unbound_tag = '0;
  logic [15:0] bind_addr = '0, snoop_addr = '0;
  logic flush_valid;
  logic [3:0] flush_tag;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_order_guard u0 (
    .clk(clk), .rst_n(rst_n),
    .bind_valid(bind_valid), .bind_tag(bind_tag), .bind_addr(bind_addr), .bind_noncoh(bind_noncoh),
    .retire_valid(retire_valid), .retire_tag(retire_tag),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .unbound_valid(unbound_valid), .unbound_tag(unbound_tag),
    .flush_valid(flush_valid), .flush_tag(flush_tag)
  );

  task automatic chk(input string req, input logic ef, input logic [3:0] et);
    logic [4:0] act, exp;
    act = {flush_valid, flush_valid ? flush_tag : 4'd0};
    exp = {ef, ef ? et : 4'd0};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: flush valid/tag actual=%b/%0d expected=%b/%0d", req, act[4], act[3:0], exp[4], exp[3:0]);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    bind_valid = v.bv; bind_tag = v.bt; bind_addr = v.ba; bind_noncoh = v.nc;
    retire_valid = v.rv; retire_tag = v.rt;
    snoop_valid = v.sv; snoop_addr = v.sa;
    unbound_valid = v.uv; unbound_tag = v.ut;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog R1: actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", 1'b0, 4'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 chk("R1 after reset", 1'b0, 4'd0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k]);
      chk($sformatf("R2-vector %0d", k), VEC[k].ef, VEC[k].et);
    end

    // R1: reset mid-run forgets tracked loads
    step('{1,4'd11,16'h7770,0, 0,4'd0, 0,16'h0000, 1,4'd11, 0,4'd0});
    @(negedge clk) rst_n = 1'b0;
    bind_valid = 0; snoop_valid = 1; snoop_addr = 16'h7770;
    @(posedge clk); #1 chk("R1 snoop during reset", 1'b0, 4'd0);
    @(negedge clk) rst_n = 1'b1;
    step('{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h7770, 1,4'd11, 0,4'd0});
    chk("R1 tracking cleared", 1'b0, 4'd0);

    // R3: neighbouring line does not match
    step('{1,4'd13,16'h3330,0, 0,4'd0, 0,16'h0000, 1,4'd13, 0,4'd0});
    step('{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h3340, 1,4'd13, 0,4'd0});
    chk("R3 other line", 1'b0, 4'd0);
    step('{0,4'd0,16'h0000,0, 0,4'd0, 1,16'h3331, 1,4'd13, 0,4'd0});
    chk("R3 same line", 1'b1, 4'd13);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule